// File: doc/BRIEF.md
# Nonce-Chunk Message Schedule Pipeline

This block generates the SHA-256 message schedule for the second 512-bit chunk of an 80-byte mining header. Only four words of that chunk change between attempts: the last word of the Merkle root, the timestamp, the difficulty bits and the nonce. The other twelve words are fixed padding and length. Because those twelve words are wired in as constants, the block never registers them. The early schedule words are then computed with fewer adders and sigma functions than the general recurrence needs.

A new set of four words may be presented on every clock. The pipeline has one register stage per compression round from 4 to the last round configured, and each stage outputs one schedule word together with a valid bit. Stage j shows word Wj exactly j-3 clocks after its four input words were accepted. A round pipeline that takes its fourth round from the first stage can therefore read each stage output in the cycle it consumes that word. The carried state is only the input words up to stage 19. It grows towards sixteen words after that, and shrinks again near the end as words stop being needed.

Top module: `nchunk_sched`

## Requirements
- R1: A synchronous active-high reset clears every output valid bit on the next clock edge. Input frames accepted before or during reset never appear as valid.
- R2: Output valid bit k (stage j = k+4) equals `in_valid` as it was sampled j-3 clock edges earlier, as long as no reset occurred in between.
- R3: Stages 4 to 15 output the fixed padding words: 0x80000000 at stage 4, zero at stages 5 to 14, and 0x00000280 at stage 15.
- R4: Stages 16 to 19 output W16..W19 equal to the full SHA-256 recurrence over the padded chunk. In that chunk, W0..W3 are `in_words[31:0]`, `[63:32]`, `[95:64]` and `[127:96]`.
- R5: Stages 20 and 21 output W20 = σ1(W18)+0x80000000 and W21 = σ1(W19). Both equal the full recurrence.
- R6: Stages 22 to 30 output W22..W30 equal to the full recurrence, where σ0 is ROTR7^ROTR18^SHR3 and σ1 is ROTR17^ROTR19^SHR10.
- R7: Stages 31 to 63 output the full recurrence σ1(Wj-2)+Wj-7+σ0(Wj-15)+Wj-16 (mod 2^32).
- R8: A new frame may enter on every clock. Frames entered back to back come out on consecutive cycles at every stage, with no interaction between them.
- R9: A cycle with `in_valid` low inserts a bubble that travels down the stages as a low valid bit. It does not disturb the words of the frames around it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the valid bits |
| in_valid | input | 1 | Input words are valid this cycle |
| in_words | input | 128 | Variable words W0..W3, with W0 in bits 31:0 |
| out_valid | output | LAST_ROUND-3 | Valid bit per stage; bit k belongs to stage k+4 |
| out_words | output | 32*(LAST_ROUND-3) | Schedule word per stage; bits 32k+31:32k hold the word of stage k+4 |

## Verification
The bench builds the block with its default LAST_ROUND of 63, so all sixty stages are present. This covers every shortened formula variant as well as the full-recurrence tail. Every stage is compared on every cycle against a model that expands the whole padded chunk, so each reduced formula is checked against the full recurrence rather than against itself. The stimulus includes random words, extreme patterns (all zeros, all ones, alternating bits), back-to-back frames, random bubbles and a reset while frames are in flight.

// File: rtl/nchunk_sched_pkg.sv
package nchunk_sched_pkg;

  localparam int WORD_W = 32;
  localparam int WIN    = 16;   // words spanned by the recurrence
  localparam int N_VAR  = 4;    // variable words at the head of the chunk
  localparam int LEN_IX = 15;   // index of the length word

  // recurrence lags
  localparam int LAG_A = 2;
  localparam int LAG_B = 7;
  localparam int LAG_C = 15;
  localparam int LAG_D = 16;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t ssig0(input word_t x);
    return {x[6:0], x[31:7]} ^ {x[17:0], x[31:18]} ^ (x >> 3);
  endfunction

  function automatic word_t ssig1(input word_t x);
    return {x[16:0], x[31:17]} ^ {x[18:0], x[31:19]} ^ (x >> 10);
  endfunction

  // fixed words of the padded 80-byte-header tail chunk
  function automatic bit is_fixed(input int i);
    return (i >= N_VAR) && (i < WIN);
  endfunction

  function automatic word_t pad_word(input int i);
    if (i == N_VAR)  return 32'h8000_0000;
    if (i == LEN_IX) return 32'h0000_0280;
    return '0;
  endfunction

  function automatic bit is_zero(input int i);
    return (i < 0) || (is_fixed(i) && (pad_word(i) == '0));
  endfunction

  // a variable word i is carried by stage j when a later stage reads it
  function automatic bit keep_word(input int i, input int j, input int last);
    if (i < 0 || is_fixed(i) || i > j) return 1'b0;
    return ((i + LAG_A > j) && (i + LAG_A <= last)) ||
           ((i + LAG_B > j) && (i + LAG_B <= last)) ||
           ((i + LAG_C > j) && (i + LAG_C <= last)) ||
           ((i + LAG_D > j) && (i + LAG_D <= last));
  endfunction

endpackage

// File: rtl/nchunk_sched_word.sv
module nchunk_sched_word
  import nchunk_sched_pkg::*;
#(
  parameter int J = 16
) (
  input  logic [WIN*WORD_W-1:0] win_i,
  output word_t                 w_o
);

  // win_i holds words J-WIN .. J-1; word i sits in slot i-(J-WIN)
  localparam int S_A = WIN - LAG_A;
  localparam int S_B = WIN - LAG_B;
  localparam int S_C = WIN - LAG_C;
  localparam int S_D = WIN - LAG_D;

  word_t t_a, t_b, t_c, t_d;
  logic  win_unused;
  assign win_unused = ^win_i;

  if (!is_zero(J - LAG_A)) begin : g_ta
    assign t_a = ssig1(win_i[S_A*WORD_W +: WORD_W]);
  end else begin : g_ta0
    assign t_a = '0;
  end

  if (!is_zero(J - LAG_B)) begin : g_tb
    assign t_b = win_i[S_B*WORD_W +: WORD_W];
  end else begin : g_tb0
    assign t_b = '0;
  end

  if (!is_zero(J - LAG_C)) begin : g_tc
    assign t_c = ssig0(win_i[S_C*WORD_W +: WORD_W]);
  end else begin : g_tc0
    assign t_c = '0;
  end

  if (!is_zero(J - LAG_D)) begin : g_td
    assign t_d = win_i[S_D*WORD_W +: WORD_W];
  end else begin : g_td0
    assign t_d = '0;
  end

  assign w_o = t_a + t_b + t_c + t_d;

endmodule

// File: rtl/nchunk_sched_stage.sv
module nchunk_sched_stage
  import nchunk_sched_pkg::*;
#(
  parameter int J    = 4,
  parameter int LAST = 63
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  vld_i,
  input  logic [WIN*WORD_W-1:0] win_i,
  output logic                  vld_o,
  output logic [WIN*WORD_W-1:0] win_o
);

  // win_o slot p holds word BASE+p
  localparam int BASE = J - (WIN - 1);

  word_t fresh;
  logic  win_unused;
  assign win_unused = ^win_i;

  always_ff @(posedge clk) begin
    if (rst) vld_o <= 1'b0;
    else     vld_o <= vld_i;
  end

  if (J >= WIN) begin : g_calc
    nchunk_sched_word #(.J(J)) u_word (
      .win_i (win_i),
      .w_o   (fresh)
    );
  end else begin : g_fix
    assign fresh = pad_word(J);
  end

  for (genvar p = 0; p < WIN; p++) begin : g_slot
    localparam int IDX = BASE + p;
    word_t q;
    if (p == WIN - 1) begin : g_new
      if (J >= WIN) begin : g_reg
        always_ff @(posedge clk) q <= fresh;
      end else begin : g_const
        assign q = fresh;
      end
    end else if (is_fixed(IDX)) begin : g_pad
      assign q = pad_word(IDX);
    end else if (keep_word(IDX, J, LAST)) begin : g_carry
      always_ff @(posedge clk) q <= win_i[(p+1)*WORD_W +: WORD_W];
    end else begin : g_drop
      assign q = '0;
    end
    assign win_o[p*WORD_W +: WORD_W] = q;
  end

endmodule

// File: rtl/nchunk_sched.sv
module nchunk_sched
  import nchunk_sched_pkg::*;
#(
  parameter int LAST_ROUND = 63
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     in_valid,
  input  logic [N_VAR*WORD_W-1:0]                  in_words,
  output logic [LAST_ROUND-N_VAR:0]                out_valid,
  output logic [(LAST_ROUND-N_VAR+1)*WORD_W-1:0]   out_words
);

  localparam int FIRST = N_VAR;
  localparam int HEAD  = FIRST - 1;

  logic [WIN*WORD_W-1:0] win [HEAD:LAST_ROUND];
  logic [LAST_ROUND:HEAD] vld;

  // head window: words HEAD-15 .. HEAD taken straight from the inputs
  for (genvar p = 0; p < WIN; p++) begin : g_head
    localparam int IDX = HEAD - (WIN - 1) + p;
    if (IDX >= 0) begin : g_in
      assign win[HEAD][p*WORD_W +: WORD_W] = in_words[IDX*WORD_W +: WORD_W];
    end else begin : g_none
      assign win[HEAD][p*WORD_W +: WORD_W] = '0;
    end
  end
  assign vld[HEAD] = in_valid;

  for (genvar j = FIRST; j <= LAST_ROUND; j++) begin : g_stg
    nchunk_sched_stage #(.J(j), .LAST(LAST_ROUND)) u_stage (
      .clk   (clk),
      .rst   (rst),
      .vld_i (vld[j-1]),
      .win_i (win[j-1]),
      .vld_o (vld[j]),
      .win_o (win[j])
    );
    assign out_valid[j-FIRST] = vld[j];
    assign out_words[(j-FIRST)*WORD_W +: WORD_W] = win[j][(WIN-1)*WORD_W +: WORD_W];
  end

  logic tail_unused;
  assign tail_unused = ^win[LAST_ROUND][(WIN-1)*WORD_W-1:0];

endmodule

// File: rtl/nchunk_sched_chk.sv
module nchunk_sched_chk
  import nchunk_sched_pkg::*;
#(
  parameter int LAST_ROUND = 63
) (
  input logic                                   clk,
  input logic                                   rst,
  input logic                                   in_valid,
  input logic [LAST_ROUND-N_VAR:0]              out_valid,
  input logic [(LAST_ROUND-N_VAR+1)*WORD_W-1:0] out_words
);

  localparam int N_STG = LAST_ROUND - N_VAR + 1;

  // R1: reset empties the pipeline
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (out_valid == '0));

  // R2: first stage follows the input valid by one edge
  p_head_valid_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid[0] == $past(in_valid)));

  for (genvar k = 1; k < N_STG; k++) begin : g_vchain
    // R2: each stage follows its predecessor by one edge
    p_valid_chain_r2: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (out_valid[k] == $past(out_valid[k-1])));
  end

  if (LAST_ROUND >= 21) begin : g_w21
    // R5: W21 is sigma1 of the word stage 19 showed two cycles earlier
    p_w21_short_r5: assert property (@(posedge clk) disable iff (rst)
      out_valid[21-N_VAR] |->
        (out_words[(21-N_VAR)*WORD_W +: WORD_W] ==
         ssig1($past(out_words[(19-N_VAR)*WORD_W +: WORD_W], 2))));
  end

  for (genvar j = 22; j <= 29 && j <= LAST_ROUND; j++) begin : g_mid
    // R6: two-term words across stage outputs
    p_mid_terms_r6: assert property (@(posedge clk) disable iff (rst)
      out_valid[j-N_VAR] |->
        (out_words[(j-N_VAR)*WORD_W +: WORD_W] ==
         ssig1($past(out_words[(j-2-N_VAR)*WORD_W +: WORD_W], 2)) +
         $past(out_words[(j-7-N_VAR)*WORD_W +: WORD_W], 7)));
  end

  for (genvar j = 31; j <= LAST_ROUND; j++) begin : g_tail
    // R7: full recurrence across stage outputs
    p_full_recur_r7: assert property (@(posedge clk) disable iff (rst)
      out_valid[j-N_VAR] |->
        (out_words[(j-N_VAR)*WORD_W +: WORD_W] ==
         ssig1($past(out_words[(j-2-N_VAR)*WORD_W +: WORD_W], 2)) +
         $past(out_words[(j-7-N_VAR)*WORD_W +: WORD_W], 7) +
         ssig0($past(out_words[(j-15-N_VAR)*WORD_W +: WORD_W], 15)) +
         $past(out_words[(j-16-N_VAR)*WORD_W +: WORD_W], 16)));
  end

endmodule

bind nchunk_sched nchunk_sched_chk #(.LAST_ROUND(LAST_ROUND)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_words (out_words)
);

// File: tb/nchunk_sched_tb_top.sv
`timescale 1ns/1ps
module nchunk_sched_tb_top;

  localparam int LAST = 63;
  localparam int NST  = LAST - 3;
  localparam int HN   = 128;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [127:0]      in_words = '0;
  logic [NST-1:0]    out_valid;
  logic [NST*32-1:0] out_words;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  logic [31:0] exp_w [0:HN-1][0:63];
  bit          hist_vld [0:HN-1];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nchunk_sched #(.LAST_ROUND(LAST)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_words  (in_words),
    .out_valid (out_valid),
    .out_words (out_words)
  );

  function automatic logic [31:0] ror(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction
  function automatic logic [31:0] sg0(input logic [31:0] x);
    return ror(x, 7) ^ ror(x, 18) ^ (x >> 3);
  endfunction
  function automatic logic [31:0] sg1(input logic [31:0] x);
    return ror(x, 17) ^ ror(x, 19) ^ (x >> 10);
  endfunction

  function automatic string req_of(input int j);
    if (j <= 15) return "R3";
    if (j <= 19) return "R4";
    if (j <= 21) return "R5";
    if (j <= 30) return "R6";
    return "R7";
  endfunction

  // full standard expansion of the padded chunk
  task automatic put_frame(input int slot, input logic [127:0] m, input bit v);
    logic [31:0] w [0:63];
    for (int i = 0; i < 16; i++) begin
      if (i < 4)        w[i] = m[i*32 +: 32];
      else if (i == 4)  w[i] = 32'h8000_0000;
      else if (i == 15) w[i] = 32'h0000_0280;
      else              w[i] = 32'h0;
    end
    for (int i = 16; i < 64; i++)
      w[i] = sg1(w[i-2]) + w[i-7] + sg0(w[i-15]) + w[i-16];
    for (int i = 0; i < 64; i++) exp_w[slot][i] = w[i];
    hist_vld[slot] = v;
  endtask

  task automatic check_all(input string tag);
    for (int j = 4; j <= LAST; j++) begin
      int  q = cyc - (j - 4);
      bit  ev = (q >= 0) ? hist_vld[q % HN] : 1'b0;
      logic [31:0] got = out_words[(j-4)*32 +: 32];
      n_chk++;
      if (out_valid[j-4] !== ev) begin
        n_fail++;
        $display("FAIL R2 %s stage %0d valid got %b exp %b", tag, j, out_valid[j-4], ev);
      end
      if (ev) begin
        n_chk++;
        if (got !== exp_w[q % HN][j]) begin
          n_fail++;
          $display("FAIL %s %s stage %0d word got %h exp %h",
                   req_of(j), tag, j, got, exp_w[q % HN][j]);
        end
      end
    end
  endtask

  // called at a falling edge: sets up what the next rising edge captures
  task automatic drive(input bit v, input logic [127:0] m, input bit r);
    int slot = (cyc + 1) % HN;
    rst      = r;
    in_valid = v;
    in_words = m;
    if (r) for (int i = 0; i < HN; i++) hist_vld[i] = 1'b0;
    put_frame(slot, m, v && !r);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic cycle(input string tag, input bit v, input logic [127:0] m, input bit r);
    @(negedge clk);
    check_all(tag);
    drive(v, m, r);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < HN; i++) hist_vld[i] = 1'b0;

    // R1: reset state, with in_valid held high during reset
    for (int i = 0; i < 3; i++) cycle("R1", 1'b1, rnd128(), 1'b1);
    @(negedge clk);
    n_chk++;
    if (out_valid !== '0) begin
      n_fail++;
      $display("FAIL R1 valids after reset got %h exp 0", out_valid);
    end
    drive(1'b1, rnd128(), 1'b0);

    // R8: back-to-back random frames
    for (int i = 0; i < 300; i++) cycle("R8", 1'b1, rnd128(), 1'b0);

    // R4 R5 R6 R7: extreme word patterns back to back
    cycle("R8", 1'b1, 128'h0, 1'b0);
    cycle("R8", 1'b1, {128{1'b1}}, 1'b0);
    cycle("R8", 1'b1, {32{4'hA}}, 1'b0);
    cycle("R8", 1'b1, {32{4'h5}}, 1'b0);
    cycle("R8", 1'b1, {32'h0, 32'h0, 32'h0, 32'h1}, 1'b0);
    cycle("R8", 1'b1, {32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0}, 1'b0);
    cycle("R8", 1'b1, {32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000}, 1'b0);
    for (int b = 0; b < 32; b++)
      cycle("R8", 1'b1, {4{32'h1 << b}}, 1'b0);

    // R9: random bubbles
    for (int i = 0; i < 300; i++) cycle("R9", ($urandom() % 3) != 0, rnd128(), 1'b0);

    // R1: reset while frames are in flight
    for (int i = 0; i < 30; i++) cycle("R8", 1'b1, rnd128(), 1'b0);
    cycle("R1", 1'b1, rnd128(), 1'b1);
    @(negedge clk);
    n_chk++;
    if (out_valid !== '0) begin
      n_fail++;
      $display("FAIL R1 valids after mid-run reset got %h exp 0", out_valid);
    end
    drive(1'b1, rnd128(), 1'b0);

    for (int i = 0; i < 100; i++) cycle("R9", ($urandom() % 2) != 0, rnd128(), 1'b0);
    for (int i = 0; i < 70; i++)  cycle("R9", 1'b0, rnd128(), 1'b0);

    summary();
    $finish;
  end

endmodule